// File: doc/BRIEF.md
# APB Eight-Pin GPIO with Address-Masked Data

This peripheral gives software control over eight general purpose pins through an APB slave port. Each pin can be an input or a driven output, can raise an interrupt on an edge or a level, and can be handed over to an alternate hardware function. Once it is handed over, that function drives the pin's value and output enable directly, and it always sees the pin's synchronized input.

The data register takes its per-bit enable from the access address. Address bits [9:2] of any access below 0x400 act as an eight-bit mask, so software can read or change any subset of pins in a single transfer. No read-modify-write sequence is needed, and another agent cannot change a neighbouring pin between the read and the write. Pin inputs are brought into the clock domain by two flops. Edge detection compares the synchronized level with its value one clock earlier. Latched edge events and live level matches feed a raw status, which is masked by the per-pin enables. The masked bits are ORed into a single interrupt line.

Top module: `gpio_apb`

## Requirements
- R1: After reset every register is 0. All pins are software-controlled inputs: pinOe is 0, pinOut is 0 and irq is 0, and every register offset reads 0.
- R2: A read at an address below 0x400 returns the synchronized pin level in each bit n for which address bit n+2 is 1. It returns 0 in every bit whose address bit is 0, and 0 in bits 31:8.
- R3: A write at an address below 0x400 loads pwdata bit n into output bit n only when address bit n+2 is 1. Every other output bit keeps its value.
- R4: The direction register is at 0x400. In software mode, pinOe[n] equals direction bit n (1 = output), and pinOut[n] equals the stored output bit n.
- R5: The mode register is at 0x420. When mode bit n is 1, pinOut[n] follows altOut[n] and pinOe[n] follows altOe[n]. altIn always carries the synchronized pin levels.
- R6: The following registers read back bits 7:0 of the last value written to them, with bits 31:8 reading 0: direction 0x400, sense 0x404, both-edges 0x408, polarity 0x40C, enable 0x410 and mode 0x420. The clear offset 0x41C reads 0, and every offset from 0x424 upward reads 0. Writes to raw status 0x414 and masked status 0x418 have no effect.
- R7: When sense bit n is 0 (edge) and both-edges bit n is 0, raw status bit n (0x414) latches on a rising edge if polarity bit n is 1, or on a falling edge if it is 0. It stays set after the pin returns to its former level.
- R8: When sense bit n is 0 and both-edges bit n is 1, either edge on the pin latches raw status bit n.
- R9: When sense bit n is 1 (level), raw status bit n is 1 exactly while the synchronized pin equals polarity bit n. It is not latched.
- R10: Writing 1 to bit n at 0x41C clears a latched edge event on pin n. Bits written 0 are left alone, and the write has no effect on level-mode status.
- R11: Masked status (0x418) equals raw status ANDed with the enable register (1 = enabled). irq is 1 exactly when any masked status bit is 1.
- R12: Every access completes in its access phase: pready is always 1 and pslverr is always 0. A write takes effect at the clock edge that ends its access phase.
- R13: A change on pinIn is not yet visible in a data read one clock edge later. It is visible after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0 |
| pinIn | input | 8 | Pin input levels (asynchronous) |
| pinOut | output | 8 | Pin output values |
| pinOe | output | 8 | Pin output enables |
| altOut | input | 8 | Output values from the alternate hardware |
| altOe | input | 8 | Output enables from the alternate hardware |
| altIn | output | 8 | Synchronized pin levels for the alternate hardware |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: eight pins, a 12-bit address and 32-bit data. At this size all 256 address masks can be swept exhaustively, for masked reads against several pin patterns and for masked writes against a running model of the output register. Every pin is taken through rising, falling, both-edge and level detection one at a time. The exact two-edge synchronizer latency is checked by watching a held read address across each edge.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;

  localparam logic [11:0] OFF_DIR    = 12'h400;
  localparam logic [11:0] OFF_SENSE  = 12'h404;
  localparam logic [11:0] OFF_BOTH   = 12'h408;
  localparam logic [11:0] OFF_POL    = 12'h40C;
  localparam logic [11:0] OFF_IE     = 12'h410;
  localparam logic [11:0] OFF_RAW    = 12'h414;
  localparam logic [11:0] OFF_MASKED = 12'h418;
  localparam logic [11:0] OFF_CLR    = 12'h41C;
  localparam logic [11:0] OFF_MODE   = 12'h420;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_DATA,
    RD_DIR,
    RD_SENSE,
    RD_BOTH,
    RD_POL,
    RD_IE,
    RD_RAW,
    RD_MASKED,
    RD_MODE
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrSense;
    logic   wrBoth;
    logic   wrPol;
    logic   wrIe;
    logic   wrClr;
    logic   wrMode;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_apb_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output regStrobe_t        strb,
  output logic [NPINS-1:0]  accMask
);

  localparam int WORD_W   = ADDR_W - 2;
  localparam int MASK_LSB = 2;
  localparam int MASK_MSB = MASK_LSB + NPINS - 1;

  localparam logic [WORD_W-1:0] W_DIR    = WORD_W'(OFF_DIR >> 2);
  localparam logic [WORD_W-1:0] W_SENSE  = WORD_W'(OFF_SENSE >> 2);
  localparam logic [WORD_W-1:0] W_BOTH   = WORD_W'(OFF_BOTH >> 2);
  localparam logic [WORD_W-1:0] W_POL    = WORD_W'(OFF_POL >> 2);
  localparam logic [WORD_W-1:0] W_IE     = WORD_W'(OFF_IE >> 2);
  localparam logic [WORD_W-1:0] W_RAW    = WORD_W'(OFF_RAW >> 2);
  localparam logic [WORD_W-1:0] W_MASKED = WORD_W'(OFF_MASKED >> 2);
  localparam logic [WORD_W-1:0] W_CLR    = WORD_W'(OFF_CLR >> 2);
  localparam logic [WORD_W-1:0] W_MODE   = WORD_W'(OFF_MODE >> 2);

  logic [WORD_W-1:0] wordIdx;
  logic              inData;
  logic              wrEn;
  logic [1:0]        unusedByteSel;

  assign wordIdx       = paddr[ADDR_W-1:2];
  assign unusedByteSel = paddr[1:0];
  // Everything below 0x400 is the masked data window
  assign inData        = (paddr[ADDR_W-1:10] == '0);
  assign wrEn          = psel & penable & pwrite;
  assign accMask       = paddr[MASK_MSB:MASK_LSB];

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (psel) begin
      if (inData) begin
        strb.rdSel  = RD_DATA;
        strb.wrData = wrEn;
      end else begin
        case (wordIdx)
          W_DIR:    begin strb.rdSel = RD_DIR;   strb.wrDir   = wrEn; end
          W_SENSE:  begin strb.rdSel = RD_SENSE; strb.wrSense = wrEn; end
          W_BOTH:   begin strb.rdSel = RD_BOTH;  strb.wrBoth  = wrEn; end
          W_POL:    begin strb.rdSel = RD_POL;   strb.wrPol   = wrEn; end
          W_IE:     begin strb.rdSel = RD_IE;    strb.wrIe    = wrEn; end
          W_RAW:    strb.rdSel = RD_RAW;
          W_MASKED: strb.rdSel = RD_MASKED;
          W_CLR:    strb.wrClr = wrEn;
          W_MODE:   begin strb.rdSel = RD_MODE;  strb.wrMode  = wrEn; end
          default:  strb.rdSel = RD_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_apb_datapath.sv
module gpio_apb_datapath
  import gpio_apb_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [NPINS-1:0]  accMask,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  pinIn,
  input  logic [NPINS-1:0]  altOut,
  input  logic [NPINS-1:0]  altOe,
  output logic [DATA_W-1:0] rdata,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinOe,
  output logic [NPINS-1:0]  altIn,
  output logic              irq,
  output logic [NPINS-1:0]  dataQ,
  output logic [NPINS-1:0]  ieQ,
  output logic [NPINS-1:0]  modeQ
);

  localparam int PAD_W = DATA_W - NPINS;

  logic [NPINS-1:0] dirQ, senseQ, bothQ, polQ;
  logic [NPINS-1:0] syncA, syncB, prevB;
  logic [NPINS-1:0] latchQ, latchNext;
  logic [NPINS-1:0] rawStat, maskStat;
  logic [NPINS-1:0] rdSmall;

  // Configuration and output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      dirQ   <= '0;
      senseQ <= '0;
      bothQ  <= '0;
      polQ   <= '0;
      ieQ    <= '0;
      modeQ  <= '0;
    end else begin
      if (strb.wrData)  dataQ  <= (dataQ & ~accMask) | (wdata & accMask);
      if (strb.wrDir)   dirQ   <= wdata;
      if (strb.wrSense) senseQ <= wdata;
      if (strb.wrBoth)  bothQ  <= wdata;
      if (strb.wrPol)   polQ   <= wdata;
      if (strb.wrIe)    ieQ    <= wdata;
      if (strb.wrMode)  modeQ  <= wdata;
    end
  end

  // Two-flop synchronizer plus one history stage for edge compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      prevB  <= '0;
      latchQ <= '0;
    end else begin
      syncA  <= pinIn;
      syncB  <= syncA;
      prevB  <= syncB;
      latchQ <= latchNext;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic riseEv, fallEv, edgeHit, levelHit;
    assign riseEv   = syncB[i] & ~prevB[i];
    assign fallEv   = ~syncB[i] & prevB[i];
    assign edgeHit  = bothQ[i] ? (riseEv | fallEv) : (polQ[i] ? riseEv : fallEv);
    assign levelHit = polQ[i] ? syncB[i] : ~syncB[i];
    // A new event in the same cycle as a clear wins
    assign latchNext[i] = (~senseQ[i] & edgeHit) |
                          (latchQ[i] & ~(strb.wrClr & wdata[i]));
    assign rawStat[i]   = senseQ[i] ? levelHit : latchQ[i];
    assign pinOut[i]    = modeQ[i] ? altOut[i] : dataQ[i];
    assign pinOe[i]     = modeQ[i] ? altOe[i]  : dirQ[i];
  end

  assign altIn    = syncB;
  assign maskStat = rawStat & ieQ;
  assign irq      = |maskStat;

  always_comb begin
    case (strb.rdSel)
      RD_DATA:   rdSmall = syncB & accMask;
      RD_DIR:    rdSmall = dirQ;
      RD_SENSE:  rdSmall = senseQ;
      RD_BOTH:   rdSmall = bothQ;
      RD_POL:    rdSmall = polQ;
      RD_IE:     rdSmall = ieQ;
      RD_RAW:    rdSmall = rawStat;
      RD_MASKED: rdSmall = maskStat;
      RD_MODE:   rdSmall = modeQ;
      default:   rdSmall = '0;
    endcase
  end

  assign rdata = {{PAD_W{1'b0}}, rdSmall};

endmodule

// File: rtl/gpio_apb.sv
module gpio_apb
  import gpio_apb_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinOe,
  input  logic [NPINS-1:0]  altOut,
  input  logic [NPINS-1:0]  altOe,
  output logic [NPINS-1:0]  altIn,
  output logic              irq
);

  regStrobe_t       strb;
  logic [NPINS-1:0] accMask;
  logic [NPINS-1:0] dataQ, ieQ, modeQ;
  logic [DATA_W-NPINS-1:0] unusedWdata;

  assign unusedWdata = pwdata[DATA_W-1:NPINS];
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  gpio_apb_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_ctrl (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .strb    (strb),
    .accMask (accMask)
  );

  gpio_apb_datapath #(.NPINS(NPINS), .DATA_W(DATA_W)) u_dp (
    .clk     (pclk),
    .rstN    (presetn),
    .strb    (strb),
    .accMask (accMask),
    .wdata   (pwdata[NPINS-1:0]),
    .pinIn   (pinIn),
    .altOut  (altOut),
    .altOe   (altOe),
    .rdata   (prdata),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .altIn   (altIn),
    .irq     (irq),
    .dataQ   (dataQ),
    .ieQ     (ieQ),
    .modeQ   (modeQ)
  );

endmodule

// File: rtl/gpio_apb_chk.sv
module gpio_apb_chk
  import gpio_apb_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [NPINS-1:0]  wdata,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [NPINS-1:0]  pinOe,
  input logic              irq,
  input logic [NPINS-1:0]  dataQ,
  input logic [NPINS-1:0]  ieQ,
  input logic [NPINS-1:0]  modeQ
);

  logic dataWr, dirWr;
  assign dataWr = psel && penable && pwrite && (paddr[ADDR_W-1:10] == '0);
  assign dirWr  = psel && penable && pwrite &&
                  (paddr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_DIR >> 2));

  // R12
  no_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    pready && !pslverr);

  // R3
  masked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> ((((dataQ ^ $past(dataQ)) & ~$past(paddr[NPINS+1:2])) == '0) &&
               ((dataQ & $past(paddr[NPINS+1:2])) ==
                ($past(wdata) & $past(paddr[NPINS+1:2])))));

  // R4
  dir_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirWr && (modeQ == '0)) |=> (pinOe == $past(wdata)));

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ieQ == '0) |-> !irq);

  // R6
  unused_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psel && !pwrite && (paddr >= ADDR_W'(12'h424))) |-> (prdata == '0));

endmodule

bind gpio_apb gpio_apb_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (pclk),
  .rstN    (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .wdata   (pwdata[NPINS-1:0]),
  .prdata  (prdata),
  .pready  (pready),
  .pslverr (pslverr),
  .pinOe   (pinOe),
  .irq     (irq),
  .dataQ   (dataQ),
  .ieQ     (ieQ),
  .modeQ   (modeQ)
);

// File: tb/gpio_apb_tb.sv
module gpio_apb_tb;

  localparam int CLK_PERIOD = 10;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  pinIn = '0, altOut = '0, altOe = '0;
  logic [7:0]  pinOut, pinOe, altIn;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  gpio_apb u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .altOut(altOut), .altOe(altOe), .altIn(altIn), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic setPins(input logic [7:0] v);
    @(negedge pclk);
    pinIn = v;
    waitCycles(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  expOut;
    logic [7:0]  pats [3];
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF;

    waitCycles(4);
    presetn = 1'b1;
    waitCycles(2);

    // R1: reset state
    check("R1 pinOe", {24'h0, pinOe}, 32'h0);
    check("R1 pinOut", {24'h0, pinOut}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R12 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);
    for (int off = 12'h400; off <= 12'h420; off += 4) begin
      apbRead(off[11:0], rd);
      check($sformatf("R1 reg %h", off), rd, 32'h0);
    end

    // R6: readback of configuration registers
    apbWrite(12'h400, 32'hFFFF_FF5A);
    apbWrite(12'h404, 32'h0000_00C3);
    apbWrite(12'h408, 32'h1234_5611);
    apbWrite(12'h40C, 32'h0000_0080);
    apbWrite(12'h410, 32'h0000_0000);
    apbWrite(12'h420, 32'h0000_0000);
    apbRead(12'h400, rd); check("R6 dir", rd, 32'h5A);
    apbRead(12'h404, rd); check("R6 sense", rd, 32'hC3);
    apbRead(12'h408, rd); check("R6 both", rd, 32'h11);
    apbRead(12'h40C, rd); check("R6 pol", rd, 32'h80);
    apbWrite(12'h410, 32'h0000_0069);
    apbRead(12'h410, rd); check("R6 ie", rd, 32'h69);
    apbWrite(12'h410, 32'h0);
    apbWrite(12'h404, 32'h0);
    apbWrite(12'h408, 32'h0);
    apbWrite(12'h40C, 32'h0);
    apbWrite(12'h400, 32'h0);
    apbWrite(12'h414, 32'hFF);
    apbWrite(12'h418, 32'hFF);
    apbRead(12'h414, rd); check("R6 raw write ignored", rd, 32'h0);
    apbRead(12'h418, rd); check("R6 masked write ignored", rd, 32'h0);
    apbRead(12'h41C, rd); check("R6 clear reads 0", rd, 32'h0);
    apbRead(12'h424, rd); check("R6 unused 424", rd, 32'h0);
    apbRead(12'hFFC, rd); check("R6 unused FFC", rd, 32'h0);
    // mode register last: with all-zero alt inputs, pinOe must stay 0
    apbWrite(12'h420, 32'hFFFF_FF96);
    apbRead(12'h420, rd); check("R6 mode", rd, 32'h96);
    apbWrite(12'h420, 32'h0);

    // R2: exhaustive mask sweep of data reads
    for (int p = 0; p < 3; p++) begin
      setPins(pats[p]);
      for (int m = 0; m < 256; m++) begin
        apbRead({2'b00, m[7:0], 2'b00}, rd);
        check($sformatf("R2 pins %h mask %h", pats[p], m), rd, {24'h0, pats[p] & m[7:0]});
      end
    end

    // R13: two-flop latency, held read at mask FF
    setPins(8'h00);
    @(negedge pclk);
    pinIn = 8'h81; psel = 1'b1; pwrite = 1'b0; paddr = 12'h3FC;
    @(negedge pclk);
    check("R13 one edge still old", prdata, 32'h00);
    @(negedge pclk);
    check("R13 two edges new", prdata, 32'h81);
    psel = 1'b0;
    setPins(8'h00);

    // R3/R4: exhaustive masked writes with all pins as outputs
    apbWrite(12'h400, 32'hFF);
    check("R4 pinOe all out", {24'h0, pinOe}, 32'hFF);
    expOut = 8'h00;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] wd;
      wd = 8'((m * 37 + 11) ^ 8'hA6);
      apbWrite({2'b00, m[7:0], 2'b00}, {24'hDEAD00, wd});
      expOut = (expOut & ~m[7:0]) | (wd & m[7:0]);
      check($sformatf("R3 mask %h data %h", m, wd), {24'h0, pinOut}, {24'h0, expOut});
    end
    apbWrite(12'h400, 32'h0F);
    check("R4 pinOe partial", {24'h0, pinOe}, 32'h0F);
    check("R4 pinOut held", {24'h0, pinOut}, {24'h0, expOut});

    // R5: alternate function hand-over on upper nibble
    @(negedge pclk);
    altOut = 8'h5A; altOe = 8'h33;
    apbWrite(12'h420, 32'hF0);
    check("R5 pinOut mux", {24'h0, pinOut}, {24'h0, (8'h5A & 8'hF0) | (expOut & 8'h0F)});
    check("R5 pinOe mux", {24'h0, pinOe}, {24'h0, (8'h33 & 8'hF0) | 8'h0F});
    setPins(8'h96);
    check("R5 altIn", {24'h0, altIn}, 32'h96);
    apbWrite(12'h420, 32'h0);
    @(negedge pclk);
    altOut = 8'h00; altOe = 8'h00;
    setPins(8'h00);
    apbWrite(12'h41C, 32'hFF);

    // R7: rising then falling edge per pin
    for (int i = 0; i < 8; i++) begin
      logic [7:0] bit1;
      bit1 = 8'(1 << i);
      apbWrite(12'h40C, 32'hFF);
      setPins(bit1);
      apbRead(12'h414, rd); check($sformatf("R7 rise pin %0d", i), rd, {24'h0, bit1});
      setPins(8'h00);
      apbRead(12'h414, rd); check($sformatf("R7 rise latched pin %0d", i), rd, {24'h0, bit1});
      apbWrite(12'h41C, {24'h0, bit1});
      apbRead(12'h414, rd); check($sformatf("R10 cleared pin %0d", i), rd, 32'h0);
      apbWrite(12'h40C, 32'h00);
      setPins(bit1);
      apbRead(12'h414, rd); check($sformatf("R7 rise ignored falling pol pin %0d", i), rd, 32'h0);
      setPins(8'h00);
      apbRead(12'h414, rd); check($sformatf("R7 fall pin %0d", i), rd, {24'h0, bit1});
      apbWrite(12'h41C, 32'hFF);
    end

    // R10: clear only the bits written 1
    apbWrite(12'h40C, 32'hFF);
    setPins(8'h24);
    setPins(8'h00);
    apbWrite(12'h41C, 32'h04);
    apbRead(12'h414, rd); check("R10 partial clear", rd, 32'h20);
    apbWrite(12'h41C, 32'hFF);

    // R8: both edges per pin
    apbWrite(12'h408, 32'hFF);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] bit1;
      bit1 = 8'(1 << i);
      setPins(bit1);
      apbRead(12'h414, rd); check($sformatf("R8 rise pin %0d", i), rd, {24'h0, bit1});
      apbWrite(12'h41C, 32'hFF);
      setPins(8'h00);
      apbRead(12'h414, rd); check($sformatf("R8 fall pin %0d", i), rd, {24'h0, bit1});
      apbWrite(12'h41C, 32'hFF);
    end
    apbWrite(12'h408, 32'h00);

    // R9/R10/R11: level detection, masking and irq
    apbWrite(12'h40C, 32'h0F);
    apbWrite(12'h404, 32'hFF);
    for (int p = 0; p < 3; p++) begin
      logic [7:0] expRaw;
      setPins(pats[p]);
      expRaw = (pats[p] & 8'h0F) | (~pats[p] & 8'hF0);
      apbRead(12'h414, rd); check($sformatf("R9 level pins %h", pats[p]), rd, {24'h0, expRaw});
      apbWrite(12'h41C, 32'hFF);
      apbRead(12'h414, rd); check($sformatf("R10 level not cleared %h", pats[p]), rd, {24'h0, expRaw});
      check($sformatf("R11 irq off ie=0 %h", pats[p]), {31'h0, irq}, 32'h0);
      apbWrite(12'h410, 32'h81);
      apbRead(12'h418, rd); check($sformatf("R11 masked %h", pats[p]), rd, {24'h0, expRaw & 8'h81});
      check($sformatf("R11 irq %h", pats[p]), {31'h0, irq}, {31'h0, |(expRaw & 8'h81)});
      apbWrite(12'h410, 32'h00);
    end
    setPins(8'h00);
    apbRead(12'h414, rd); check("R9 level follows pin", rd, 32'hF0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule